// File: doc/BRIEF.md
# Multi-Line Receive Silo with Delayed Interrupt

This block collects received characters from up to sixteen serial lines into one shared first-in first-out store. It also collects modem-status change reports and self-test codes. Each stored entry is a 15-bit word tagged with its source line. A processor-side read port returns the head entry with a valid flag in the top bit. Asserting the read strobe removes that entry.

Each line has a one-character holding stage. A fixed-priority arbiter moves at most one entry per clock into the store. A configurable timeout value selects when the level-sensitive receive interrupt request is raised. Value 0 is alarm-only mode. Value 1 is immediate mode. Any value of 2 or more is a delay counted in millisecond ticks, starting from the first entry that arrives in an empty store.

Top module: `mux_rx_silo`

## Requirements
- R1: `rdData[15]` is 1 exactly when the store holds an entry, and an empty store reads 16'h0000. A high `rdEn` removes the head entry at the next rising edge. A read strobe on an empty store changes nothing.
- R2: A character entry reads as: bits [7:0] data, [11:8] line number, bit 12 parity error, bit 13 framing error, bit 14 overrun. A strobe sampled at one rising edge is readable after the second rising edge.
- R3: Bits [14:12] = 3'b111 mark a status entry. In a status entry, bit 0 = 1 marks a self-test code, with the code in [7:4] and line 0. Bit 0 = 0 marks a modem report, with [11:8] the line and bit 1 the carrier level at the time the entry is written.
- R4: At most one entry is written per clock. Self-test codes are written first, then modem reports with the lowest line first, then characters with the lowest line first.
- R5: If a line's holding stage is still occupied when a new character arrives on that line, the old character is replaced and the new one carries the overrun flag.
- R6: While the store holds DEPTH entries, an incoming entry is dropped and the next character written carries the overrun flag. A character whose three error flags would all be set has its parity flag cleared, so it never looks like a status entry.
- R7: A `selfTest` pulse queues 8 self-test entries with codes 0 to 7, in ascending order.
- R8: With timeout 0, `irq` is raised only when the store holds at least 3/4 of DEPTH entries, or when a modem report has been written since the store was last empty.
- R9: With timeout 1, `irq` is high whenever the store is not empty.
- R10: With timeout N ≥ 2, `irq` rises after the Nth `msTick` counted while the store is not empty, or earlier at the alarm level. The tick count restarts from zero each time the store empties.
- R11: `irq` is low whenever `rxIe` is low or the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chrValid | input | LINES | Per-line received-character strobe |
| chrData | input | 8*LINES | Per-line character bytes, line i at [8i+7:8i] |
| chrParErr | input | LINES | Per-line parity error, qualified by chrValid |
| chrFrmErr | input | LINES | Per-line framing error, qualified by chrValid |
| modemChg | input | LINES | Per-line modem-status change strobe |
| carrier | input | LINES | Per-line current carrier-detect level |
| selfTest | input | 1 | Self-test completion pulse |
| rdEn | input | 1 | Pop the head entry |
| tmoCfg | input | TMO_W | Interrupt timeout setting |
| rxIe | input | 1 | Receive interrupt enable |
| msTick | input | 1 | Millisecond tick, one clock wide |
| rdData | output | 16 | Head entry with valid flag in bit 15 |
| irq | output | 1 | Receive interrupt request, level |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Simultaneous strobes.** Strobes on several lines and a modem change arrive in the same cycle. A wrong arbiter reorders or loses them.
- **Back-to-back characters on one line while a lower line wins arbitration.** A design without the replacement flag would silently lose a character.
- **Overflow.** The store is filled to DEPTH plus one. A wrong design would either corrupt the head or forget to mark the next character. The case includes a character with both parity and framing errors that arrives just after the overflow. Without the parity suppression it would be mistaken for a status entry.
- **Timeout sweep.** Each timeout value is checked tick by tick. The sweep catches off-by-one counting. It also catches a timer that counts while the store is empty, or that keeps stale ticks across a drain.

// File: rtl/mux_rx_silo_pkg.sv
package mux_rx_silo_pkg;
  localparam int ENTRY_W = 15;
  localparam logic [2:0] STAT_TAG = 3'b111;

  typedef enum logic [1:0] {
    K_NONE,
    K_DIAG,
    K_MODEM,
    K_CHAR
  } kind_t;

  typedef struct packed {
    logic               push;
    logic [ENTRY_W-1:0] word;
    logic               pop;
  } siloCmd_t;
endpackage

// File: rtl/mux_rx_silo_dp.sv
module mux_rx_silo_dp
  import mux_rx_silo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  siloCmd_t         cmd,
  output logic [15:0]      rdData,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic               doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = cmd.push && !full;
  assign doPop  = cmd.pop && !empty;
  assign rdData = empty ? 16'h0000 : {1'b1, mem[rdPtr]};

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= cmd.word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && full && !cmd.pop) |=> $stable(count)); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !cmd.push) |=> empty); // R1
endmodule

// File: rtl/mux_rx_silo_ctl.sv
module mux_rx_silo_ctl
  import mux_rx_silo_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int DIAG_N = 8,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  chrValid,
  input  logic [8*LINES-1:0] chrData,
  input  logic [LINES-1:0]  chrParErr,
  input  logic [LINES-1:0]  chrFrmErr,
  input  logic [LINES-1:0]  modemChg,
  input  logic [LINES-1:0]  carrier,
  input  logic              selfTest,
  input  logic              rdEn,
  input  logic [TMO_W-1:0]  tmoCfg,
  input  logic              rxIe,
  input  logic              msTick,
  input  logic [CNT_W-1:0]  count,
  input  logic              empty,
  input  logic              full,
  output siloCmd_t          cmd,
  output logic              irq
);
  localparam int LINE_W = $clog2(LINES);
  localparam int DG_W   = $clog2(DIAG_N + 1);
  localparam logic [CNT_W-1:0] ALARM = CNT_W'((DEPTH * 3) / 4);

  logic [7:0]       holdData [LINES];
  logic [LINES-1:0] holdFull, holdPe, holdFe, holdOv, modemPend;
  logic [DG_W-1:0]  diagLeft;
  logic [DG_W-1:0]  diagCode;
  logic             ovfPend, modemFlag, tmrDone;
  logic [TMO_W-1:0] tmrCnt;

  logic              modemHit, charHit;
  logic [LINE_W-1:0] modemSel, charSel;
  kind_t             kind;
  logic              chOv, chFe, chPe;

  // Fixed-priority pick: lowest-numbered pending line wins.
  always_comb begin
    modemHit = 1'b0;
    modemSel = '0;
    charHit  = 1'b0;
    charSel  = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (modemPend[i]) begin
        modemHit = 1'b1;
        modemSel = LINE_W'(i);
      end
      if (holdFull[i]) begin
        charHit = 1'b1;
        charSel = LINE_W'(i);
      end
    end
  end

  assign diagCode = DG_W'(DIAG_N) - diagLeft;
  assign chOv = holdOv[charSel] | ovfPend;
  assign chFe = holdFe[charSel];
  assign chPe = holdPe[charSel] & ~(chOv & chFe);

  always_comb begin
    if (diagLeft != '0)  kind = K_DIAG;
    else if (modemHit)   kind = K_MODEM;
    else if (charHit)    kind = K_CHAR;
    else                 kind = K_NONE;
  end

  always_comb begin
    cmd.pop  = rdEn;
    cmd.push = (kind != K_NONE);
    case (kind)
      K_DIAG:  cmd.word = {STAT_TAG, 4'h0, 4'(diagCode), 3'b000, 1'b1};
      K_MODEM: cmd.word = {STAT_TAG, 4'(modemSel), 6'b0, carrier[modemSel], 1'b0};
      K_CHAR:  cmd.word = {chOv, chFe, chPe, 4'(charSel), holdData[charSel]};
      default: cmd.word = '0;
    endcase
  end

  // Per-line holding stages for characters and modem reports.
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic takeChr, takeMdm;
    assign takeChr = (kind == K_CHAR)  && (charSel  == LINE_W'(g));
    assign takeMdm = (kind == K_MODEM) && (modemSel == LINE_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdFull[g] <= 1'b0;
        holdData[g] <= '0;
        holdPe[g]   <= 1'b0;
        holdFe[g]   <= 1'b0;
        holdOv[g]   <= 1'b0;
      end else if (chrValid[g]) begin
        holdFull[g] <= 1'b1;
        holdData[g] <= chrData[8*g +: 8];
        holdPe[g]   <= chrParErr[g];
        holdFe[g]   <= chrFrmErr[g];
        holdOv[g]   <= holdFull[g] && !takeChr;
      end else if (takeChr) begin
        holdFull[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            modemPend[g] <= 1'b0;
      else if (modemChg[g]) modemPend[g] <= 1'b1;
      else if (takeMdm)     modemPend[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diagLeft  <= '0;
      ovfPend   <= 1'b0;
      modemFlag <= 1'b0;
      tmrCnt    <= '0;
      tmrDone   <= 1'b0;
    end else begin
      if (selfTest)             diagLeft <= DG_W'(DIAG_N);
      else if (kind == K_DIAG)  diagLeft <= diagLeft - 1'b1;

      if (cmd.push && full)           ovfPend <= 1'b1;
      else if (kind == K_CHAR)        ovfPend <= 1'b0;

      if (kind == K_MODEM && !full)   modemFlag <= 1'b1;
      else if (empty)                 modemFlag <= 1'b0;

      if (empty) begin
        tmrCnt  <= '0;
        tmrDone <= 1'b0;
      end else if (msTick && !tmrDone) begin
        tmrCnt <= tmrCnt + 1'b1;
        if (({1'b0, tmrCnt} + 1'b1) >= {1'b0, tmoCfg}) tmrDone <= 1'b1;
      end
    end
  end

  logic alarm, modeImm, modeDly;
  assign alarm   = (count >= ALARM);
  assign modeImm = (tmoCfg == TMO_W'(1));
  assign modeDly = (tmoCfg >= TMO_W'(2));
  assign irq = rxIe && !empty &&
               (alarm || modemFlag || modeImm || (modeDly && tmrDone));

  AST_CHAR_NOT_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (kind == K_CHAR) |-> (cmd.word[14:12] != STAT_TAG)); // R6
  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    empty |=> (tmrCnt == '0)); // R10
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !irq); // R11
  AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (rxIe && modeImm && !empty) |-> irq); // R9
  AST_ALARM: assert property (@(posedge clk) disable iff (!rstN)
    (rxIe && count >= ALARM) |-> irq); // R8
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import mux_rx_silo_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int DEPTH  = 256,
  parameter int DIAG_N = 8,
  parameter int TMO_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES-1:0]   chrValid,
  input  logic [8*LINES-1:0] chrData,
  input  logic [LINES-1:0]   chrParErr,
  input  logic [LINES-1:0]   chrFrmErr,
  input  logic [LINES-1:0]   modemChg,
  input  logic [LINES-1:0]   carrier,
  input  logic               selfTest,
  input  logic               rdEn,
  input  logic [TMO_W-1:0]   tmoCfg,
  input  logic               rxIe,
  input  logic               msTick,
  output logic [15:0]        rdData,
  output logic               irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  siloCmd_t         cmd;
  logic [CNT_W-1:0] count;
  logic             empty, full;

  mux_rx_silo_ctl #(
    .LINES(LINES), .DEPTH(DEPTH), .CNT_W(CNT_W), .DIAG_N(DIAG_N), .TMO_W(TMO_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .chrValid(chrValid), .chrData(chrData),
    .chrParErr(chrParErr), .chrFrmErr(chrFrmErr),
    .modemChg(modemChg), .carrier(carrier),
    .selfTest(selfTest), .rdEn(rdEn),
    .tmoCfg(tmoCfg), .rxIe(rxIe), .msTick(msTick),
    .count(count), .empty(empty), .full(full),
    .cmd(cmd), .irq(irq)
  );

  mux_rx_silo_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rdData(rdData), .count(count), .empty(empty), .full(full)
  );
endmodule

// File: tb/mux_rx_silo_tb.sv
module mux_rx_silo_tb;
  localparam int LINES = 16;
  localparam int DEPTH = 256;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [LINES-1:0]   chrValid = '0;
  logic [8*LINES-1:0] chrData = '0;
  logic [LINES-1:0]   chrParErr = '0, chrFrmErr = '0;
  logic [LINES-1:0]   modemChg = '0, carrier = '0;
  logic               selfTest = 1'b0, rdEn = 1'b0, rxIe = 1'b0, msTick = 1'b0;
  logic [7:0]         tmoCfg = 8'd1;
  logic [15:0]        rdData;
  logic               irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mux_rx_silo u_dut (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .chrData(chrData),
    .chrParErr(chrParErr), .chrFrmErr(chrFrmErr), .modemChg(modemChg),
    .carrier(carrier), .selfTest(selfTest), .rdEn(rdEn), .tmoCfg(tmoCfg),
    .rxIe(rxIe), .msTick(msTick), .rdData(rdData), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] chrWord(int line, logic [7:0] d, bit ov, bit fe, bit pe);
    return {1'b1, ov, fe, pe, 4'(line), d};
  endfunction

  task automatic sendChar(int line, logic [7:0] d, bit pe, bit fe);
    chrValid[line] = 1'b1;
    chrData[8*line +: 8] = d;
    chrParErr[line] = pe;
    chrFrmErr[line] = fe;
    tick();
    chrValid = '0;
    chrParErr = '0;
    chrFrmErr = '0;
  endtask

  task automatic popCheck(logic [15:0] exp, string req);
    chk(rdData, exp, req);
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
  endtask

  task automatic pulseTick();
    msTick = 1'b1;
    tick();
    msTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 / R11: reset state
    chk(rdData, 16'h0000, "R1 reset empty");
    chk({15'b0, irq}, 16'h0000, "R11 reset irq");

    // R1: read on empty has no effect
    rdEn = 1'b1; tick(); rdEn = 1'b0;
    chk(rdData, 16'h0000, "R1 pop empty");
    sendChar(4, 8'h5A, 1'b0, 1'b0); tick();
    popCheck(chrWord(4, 8'h5A, 0, 0, 0), "R1 first after empty pop");
    chk(rdData, 16'h0000, "R1 drained");

    // R2: every line, distinct data and error flags
    for (int l = 0; l < LINES; l++) begin
      sendChar(l, 8'(l * 17 + 3), l[0], l[1]);
      tick();
      popCheck(chrWord(l, 8'(l * 17 + 3), 0, l[1], l[0]), "R2 line sweep");
    end

    // R3 / R4: simultaneous modem + three chars
    chrValid = 16'h0224;
    chrData[8*9 +: 8] = 8'h99; chrData[8*2 +: 8] = 8'h22; chrData[8*5 +: 8] = 8'h55;
    modemChg[7] = 1'b1; carrier[7] = 1'b1;
    tick();
    chrValid = '0; modemChg = '0;
    repeat (4) tick();
    popCheck(16'hF702, "R3 R4 modem first");
    popCheck(chrWord(2, 8'h22, 0, 0, 0), "R4 line2");
    popCheck(chrWord(5, 8'h55, 0, 0, 0), "R4 line5");
    popCheck(chrWord(9, 8'h99, 0, 0, 0), "R4 line9");
    carrier = '0;

    // R5: holding stage replaced while lower line wins
    chrValid = 16'h0021; chrData[0 +: 8] = 8'hA1; chrData[40 +: 8] = 8'hB2; tick();
    chrData[0 +: 8] = 8'hC3; chrData[40 +: 8] = 8'hD4; tick();
    chrValid = '0;
    repeat (2) tick();
    popCheck(chrWord(0, 8'hA1, 0, 0, 0), "R5 a");
    popCheck(chrWord(0, 8'hC3, 0, 0, 0), "R5 c");
    popCheck(chrWord(5, 8'hD4, 1, 0, 0), "R5 replaced overrun");
    chk(rdData, 16'h0000, "R5 lost char not stored");

    // R7: self-test codes
    selfTest = 1'b1; tick(); selfTest = 1'b0;
    repeat (8) tick();
    for (int k = 0; k < 8; k++) popCheck(16'hF001 | 16'(k << 4), "R7 diag code");
    chk(rdData, 16'h0000, "R7 exactly eight");

    // R9 / R11: immediate mode and enable gate
    rxIe = 1'b1; tmoCfg = 8'd1; tick();
    chk({15'b0, irq}, 16'h0000, "R11 empty no irq");
    sendChar(1, 8'h11, 0, 0); tick();
    chk({15'b0, irq}, 16'h0001, "R9 immediate");
    rxIe = 1'b0; #1;
    chk({15'b0, irq}, 16'h0000, "R11 disabled");
    rxIe = 1'b1;
    popCheck(chrWord(1, 8'h11, 0, 0, 0), "R9 data");
    chk({15'b0, irq}, 16'h0000, "R11 drained");

    // R8: alarm-only mode, modem report raises irq
    tmoCfg = 8'd0;
    sendChar(6, 8'h66, 0, 0); tick();
    chk({15'b0, irq}, 16'h0000, "R8 char alone");
    modemChg[3] = 1'b1; tick(); modemChg = '0; tick();
    chk({15'b0, irq}, 16'h0001, "R8 modem irq");
    popCheck(chrWord(6, 8'h66, 0, 0, 0), "R8 char");
    popCheck(16'hF300, "R3 modem carrier low");
    tick();
    chk({15'b0, irq}, 16'h0000, "R8 cleared");

    // R10: timeout sweep
    for (int t = 2; t <= 5; t++) begin
      tmoCfg = 8'(t);
      repeat (3) pulseTick();   // ticks while empty must not count
      sendChar(7, 8'(t), 0, 0); tick();
      for (int k = 1; k <= t; k++) begin
        chk({15'b0, irq}, 16'h0000, "R10 before expiry");
        pulseTick();
      end
      chk({15'b0, irq}, 16'h0001, "R10 expiry");
      popCheck(chrWord(7, 8'(t), 0, 0, 0), "R10 data");
      tick();
      chk({15'b0, irq}, 16'h0000, "R10 cleared");
    end

    // R8 / R6: alarm level and overflow
    tmoCfg = 8'd0;
    for (int i = 0; i < 191; i++) sendChar(0, 8'(i), 0, 0);
    tick();
    chk({15'b0, irq}, 16'h0000, "R8 below alarm");
    sendChar(0, 8'd191, 0, 0); tick();
    chk({15'b0, irq}, 16'h0001, "R8 alarm");
    for (int i = 192; i < DEPTH; i++) sendChar(0, 8'(i), 0, 0);
    tick();
    sendChar(0, 8'hEE, 0, 0); tick();
    popCheck(chrWord(0, 8'h00, 0, 0, 0), "R6 head intact");
    sendChar(2, 8'h55, 1, 1); tick();
    for (int i = 1; i < DEPTH; i++) popCheck(chrWord(0, 8'(i), 0, 0, 0), "R6 drain order");
    popCheck(16'hE255, "R6 overrun marked parity cleared");
    chk(rdData, 16'h0000, "R6 dropped entry absent");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule